// File: doc/BRIEF.md
# Two-Bank USB OUT Endpoint Receive Buffer

This block stores incoming data for one bulk OUT endpoint in two ping-pong banks, each one maximum packet (64 bytes by default) deep, for 128 bytes in all. The USB side streams bytes into whichever bank is free. It closes each packet with a good-packet or a bad-packet strobe. A good packet commits its bank and latches that bank's byte count. A bad packet rewinds the bank's write pointer, so the bank can be filled again.

The CPU or a DMA engine drains the oldest committed bank through a read port that advances by one byte per read strobe. A read-done strobe hands that bank back to the USB side. The block reports that a packet is waiting, the size of the oldest waiting packet, and a DMA request while unread bytes remain. When both banks hold packets, it raises a busy flag that the protocol engine turns into a NAK. A clear strobe empties both banks at once.

Top module: `usb_rx_pingpong`

## Requirements
- R1: After reset, `full`, `busy` and `dma_req` are 0 and `rx_size` is 0. Whenever `full` is 0, `rx_size` is 0.
- R2: A `pkt_good` pulse with a free bank commits that bank. From the next cycle, `full` is 1 and `rx_size` equals the number of `wr_valid` bytes accepted since the previous packet end.
- R3: While a bank is committed, `rd_data` presents its bytes in the order they were written. Each `rd_en` cycle moves to the next byte.
- R4: `dma_req` is 1 exactly while the oldest committed bank still has unread bytes. It falls in the cycle after the last byte is read.
- R5: `rd_done` frees the oldest committed bank. `full` and `rx_size` then describe the other bank if it is committed; otherwise `full` falls. `full` and `rx_size` do not change while no `rd_done` or `clr` occurs.
- R6: A `pkt_bad` pulse discards the bytes of the packet in progress and does not raise `full`. The next good packet holds only its own bytes.
- R7: With both banks committed, `busy` is 1. Bytes and `pkt_good` pulses arriving then are ignored and leave `rx_size` unchanged.
- R8: Bytes beyond 64 in one packet are dropped. `rx_size` saturates at 64, and the first 64 bytes are kept.
- R9: A `clr` pulse empties both banks. In the next cycle, `full`, `busy` and `dma_req` are 0.
- R10: `rd_done` while no bank is committed has no effect. The next good packet is reported normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Empty both banks |
| wr_valid | input | 1 | USB-side byte strobe |
| wr_data | input | 8 | USB-side byte |
| pkt_good | input | 1 | Packet ended without error |
| pkt_bad | input | 1 | Packet ended in error |
| busy | output | 1 | Both banks committed; NAK new packets |
| rd_en | input | 1 | Advance read pointer by one byte |
| rd_done | input | 1 | Release oldest committed bank |
| rd_data | output | 8 | Current byte of the oldest committed bank |
| full | output | 1 | A committed packet is waiting |
| rx_size | output | 7 | Byte count of the oldest committed packet |
| dma_req | output | 1 | Unread bytes remain in the oldest committed bank |

## Verification
Single packets of assorted lengths check the commit, the latched count, the byte order and the fall of the DMA request. Back-to-back packets tell apart the oldest-first size report and the bank swap on release, and show that a third packet is refused while busy. An aborted packet followed by a short good one shows that the write pointer was rewound. A 70-byte packet separates saturation from wraparound. A clear with both banks loaded, and a release with nothing pending, check that neither state is left out of step.

// File: rtl/usb_rx_pingpong.sv
module usb_rx_pingpong #(
  parameter int PKT_MAX = 64,
  parameter int DW      = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           wr_valid,
  input  logic [DW-1:0]                  wr_data,
  input  logic                           pkt_good,
  input  logic                           pkt_bad,
  output logic                           busy,
  input  logic                           rd_en,
  input  logic                           rd_done,
  output logic [DW-1:0]                  rd_data,
  output logic                           full,
  output logic [$clog2(PKT_MAX+1)-1:0]   rx_size,
  output logic                           dma_req
);
  localparam int AW = $clog2(PKT_MAX);
  localparam int CW = $clog2(PKT_MAX + 1);

  logic [DW-1:0] mem [2*PKT_MAX];
  logic [1:0]    cmt;
  logic [CW-1:0] cnt [2];
  logic          wbank, rbank;
  logic [CW-1:0] wr_ptr, rd_ptr;

  wire wr_free = !cmt[wbank];
  wire wr_take = wr_valid && wr_free && !pkt_good && !pkt_bad && !clr
                 && (wr_ptr < CW'(PKT_MAX));
  wire rd_step = rd_en && dma_req;

  assign full    = cmt[rbank];
  assign busy    = cmt[wbank];
  assign dma_req = cmt[rbank] && (rd_ptr < cnt[rbank]);
  assign rx_size = full ? cnt[rbank] : '0;
  assign rd_data = mem[{rbank, rd_ptr[AW-1:0]}];

  always_ff @(posedge clk)
    if (wr_take) mem[{wbank, wr_ptr[AW-1:0]}] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt    <= '0;
      wbank  <= 1'b0;
      rbank  <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      for (int b = 0; b < 2; b++) cnt[b] <= '0;
    end else if (clr) begin
      cmt    <= '0;
      wbank  <= 1'b0;
      rbank  <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      for (int b = 0; b < 2; b++) cnt[b] <= '0;
    end else begin
      if (wr_take) wr_ptr <= wr_ptr + 1'b1;
      if (pkt_bad) begin
        wr_ptr <= '0;
      end else if (pkt_good && wr_free) begin
        cmt[wbank] <= 1'b1;
        cnt[wbank] <= wr_ptr;
        wbank      <= ~wbank;
        wr_ptr     <= '0;
      end
      if (rd_step) rd_ptr <= rd_ptr + 1'b1;
      if (rd_done && cmt[rbank]) begin
        cmt[rbank] <= 1'b0;
        rbank      <= ~rbank;
        rd_ptr     <= '0;
      end
    end
  end
endmodule

// File: rtl/usb_rx_pingpong_chk.sv
module usb_rx_pingpong_chk #(
  parameter int PKT_MAX = 64,
  parameter int DW      = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         clr,
  input logic                         pkt_good,
  input logic                         pkt_bad,
  input logic                         rd_done,
  input logic                         busy,
  input logic                         full,
  input logic [$clog2(PKT_MAX+1)-1:0] rx_size,
  input logic                         dma_req
);
  localparam int CW = $clog2(PKT_MAX + 1);

  AST_IDLE_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !full |-> rx_size == '0); // R1
  AST_GOOD_COMMITS: assert property (@(posedge clk) disable iff (!rst_n) (pkt_good && !busy && !pkt_bad && !clr) |=> full); // R2
  AST_DMA_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> full); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (full && !rd_done && !clr) |=> full); // R5
  AST_SIZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (full && !rd_done && !clr) |=> $stable(rx_size)); // R5
  AST_BAD_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n) (!full && pkt_bad) |=> !full); // R6
  AST_BUSY_IMPLIES_FULL: assert property (@(posedge clk) disable iff (!rst_n) busy |-> full); // R7
  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) rx_size <= CW'(PKT_MAX)); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (!full && !busy && !dma_req)); // R9
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n) (!full && rd_done && !pkt_good) |=> !full); // R10
endmodule

bind usb_rx_pingpong usb_rx_pingpong_chk #(.PKT_MAX(PKT_MAX), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .pkt_good(pkt_good), .pkt_bad(pkt_bad),
  .rd_done(rd_done), .busy(busy), .full(full), .rx_size(rx_size), .dma_req(dma_req)
);

// File: tb/usb_rx_pingpong_tb_top.sv
`timescale 1ns/1ps
module usb_rx_pingpong_tb_top;
  logic clk = 0, rst_n = 0, clr = 0, wr_valid = 0, pkt_good = 0, pkt_bad = 0;
  logic rd_en = 0, rd_done = 0;
  logic [7:0] wr_data = 0;
  logic busy, full, dma_req;
  logic [7:0] rd_data;
  logic [6:0] rx_size;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  usb_rx_pingpong dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_data(wr_data),
    .pkt_good(pkt_good), .pkt_bad(pkt_bad), .busy(busy), .rd_en(rd_en),
    .rd_done(rd_done), .rd_data(rd_data), .full(full), .rx_size(rx_size),
    .dma_req(dma_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int n, input logic [7:0] seed, input bit good);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_valid = 1; wr_data = seed + 8'(i);
    end
    @(negedge clk); wr_valid = 0;
    if (good) pkt_good = 1; else pkt_bad = 1;
    @(negedge clk); pkt_good = 0; pkt_bad = 0;
  endtask

  task automatic read_pkt(input int n, input logic [7:0] seed, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 0;
      check(dma_req == 1, "R4", dma_req, 1);
      check(rd_data == seed + 8'(i), req, rd_data, seed + 8'(i));
      rd_en = 1;
    end
    @(negedge clk); rd_en = 0;
    check(dma_req == 0, "R4", dma_req, 0);
  endtask

  task automatic release_bank();
    @(negedge clk); rd_done = 1;
    @(negedge clk); rd_done = 0;
  endtask

  task automatic t_reset();
    check(!full && !busy && !dma_req, "R1", {full, busy, dma_req}, 0);
    check(rx_size == 0, "R1", rx_size, 0);
  endtask

  task automatic t_single();
    send_pkt(5, 8'h10, 1);
    check(full == 1, "R2", full, 1);
    check(rx_size == 5, "R2", rx_size, 5);
    check(busy == 0, "R7", busy, 0);
    read_pkt(5, 8'h10, "R3");
    check(full == 1, "R5", full, 1);
    release_bank();
    check(full == 0, "R5", full, 0);
    check(rx_size == 0, "R1", rx_size, 0);
  endtask

  task automatic t_bad();
    send_pkt(7, 8'h70, 0);
    check(full == 0, "R6", full, 0);
    send_pkt(3, 8'h40, 1);
    check(rx_size == 3, "R6", rx_size, 3);
    read_pkt(3, 8'h40, "R6");
    release_bank();
  endtask

  task automatic t_two();
    send_pkt(4, 8'hA0, 1);
    send_pkt(6, 8'hB0, 1);
    check(busy == 1, "R7", busy, 1);
    check(rx_size == 4, "R5", rx_size, 4);
    send_pkt(2, 8'hE0, 1);
    check(busy == 1, "R7", busy, 1);
    check(rx_size == 4, "R7", rx_size, 4);
    read_pkt(4, 8'hA0, "R3");
    release_bank();
    check(full == 1, "R5", full, 1);
    check(busy == 0, "R7", busy, 0);
    check(rx_size == 6, "R5", rx_size, 6);
    read_pkt(6, 8'hB0, "R7");
    release_bank();
    check(full == 0, "R5", full, 0);
  endtask

  task automatic t_overflow();
    send_pkt(70, 8'h00, 1);
    check(rx_size == 64, "R8", rx_size, 64);
    read_pkt(64, 8'h00, "R8");
    release_bank();
  endtask

  task automatic t_clear();
    send_pkt(3, 8'h30, 1);
    send_pkt(2, 8'h50, 1);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    check(!full && !busy && !dma_req, "R9", {full, busy, dma_req}, 0);
    check(rx_size == 0, "R9", rx_size, 0);
    send_pkt(2, 8'hC0, 1);
    check(rx_size == 2, "R9", rx_size, 2);
    read_pkt(2, 8'hC0, "R9");
    release_bank();
  endtask

  task automatic t_idle_done();
    release_bank();
    check(full == 0, "R10", full, 0);
    send_pkt(1, 8'hD5, 1);
    check(full == 1 && rx_size == 1, "R10", rx_size, 1);
    read_pkt(1, 8'hD5, "R10");
    release_bank();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_bad();
    t_two();
    t_overflow();
    t_clear();
    t_idle_done();
    summary();
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end
endmodule